// File: doc/BRIEF.md
# Test Status Mailbox with Run Watchdog

This block watches a single memory-mapped mailbox written by a program running on a processor under test. On each write strobe it inspects the least significant byte of the written word and acts on it. Printable characters are passed on as a byte stream with a one-cycle valid pulse, ready for a console collector. Two reserved codes end the run: one marks success and one marks failure. After the run has ended, the mailbox takes no further action.

The block also keeps a free-running cycle counter from its own reset. The counter drives two outputs. The first is an active-low system reset, which holds the surrounding logic in reset for the first few cycles. The second is a sticky timeout flag, raised when the run uses up its cycle budget without reporting a result. The cycle budget and the reset-release point are parameters.

Top module: `run_mailbox`

## Requirements
- R1: Only bits [7:0] of `wr_data` are decoded. The upper bits never change how a write is treated.
- R2: A write whose low byte lies in 0x06..0x7E, with `wr_en` high at clock edge k, drives `char_valid` high for exactly the cycle after edge k. `char_byte` holds that byte during the same cycle.
- R3: A write of low byte 0xFF sets `pass_flag` and `done_flag`. Both flags stay set until reset.
- R4: A write of low byte 0x01 sets `fail_flag` and `done_flag`. Both flags stay set until reset.
- R5: A write of low byte 0x00, 0x02..0x05 or 0x7F..0xFE has no effect on `char_valid` or on any flag.
- R6: After reset, `cycle_count` reads 0. It then rises by one at every clock edge and holds once it reaches its maximum value.
- R7: `timeout_flag` first reads 1 in the cycle where `cycle_count` equals `TIMEOUT_CYCLES`. It stays set until reset.
- R8: `sys_rst_n` is 0 while `cycle_count` <= `RELEASE_AFTER` (default 5). It is 1 from the first cycle where `cycle_count` exceeds that value.
- R9: Once `done_flag` or `timeout_flag` is set, later writes do not pulse `char_valid` and do not change `pass_flag`, `fail_flag` or `done_flag`. Once `done_flag` is set, `timeout_flag` is never raised.
- R10: If a 0xFF or 0x01 write is taken at the same edge that would raise the timeout, the result is recorded and `timeout_flag` stays 0.
- R11: A low level on `rst_n` clears the counter, every flag, `char_valid`, `char_byte` and `sys_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| wr_en | input | 1 | Write strobe to the mailbox location |
| wr_data | input | DATA_W | Written word; only bits [7:0] are decoded |
| char_valid | output | 1 | One-cycle pulse for an emitted character |
| char_byte | output | 8 | Emitted character |
| pass_flag | output | 1 | Sticky success result |
| fail_flag | output | 1 | Sticky failure result |
| done_flag | output | 1 | Sticky result-received flag |
| timeout_flag | output | 1 | Sticky cycle-budget-expired flag |
| sys_rst_n | output | 1 | Delayed active-low reset for the surrounding system |
| cycle_count | output | CNT_W | Cycles since reset, saturating |

## Verification
The case hardest to reach is a result code that lands on the same edge at which the timeout would be raised. From the ports, that edge can only be found by counting cycles. The bench uses a small `TIMEOUT_CYCLES`, clocks until `cycle_count` reads one below the budget, and drives a 0xFF write at that point. It then checks that the result is recorded, that the timeout never appears, and that the counter still advances. A run is also driven into timeout and then into a reported result, to show that each state freezes the mailbox against the other.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Classification of one mailbox write
  typedef enum logic [1:0] {
    MBX_IDLE = 2'd0,
    MBX_CHAR = 2'd1,
    MBX_PASS = 2'd2,
    MBX_FAIL = 2'd3
  } mbx_kind_e;

  localparam int unsigned MBX_CODE_W = 8;

  // Reserved result codes and the exclusive bounds of the character window
  localparam logic [MBX_CODE_W-1:0] MBX_CODE_PASS = 8'hFF;
  localparam logic [MBX_CODE_W-1:0] MBX_CODE_FAIL = 8'h01;
  localparam logic [MBX_CODE_W-1:0] MBX_CHAR_LO   = 8'h05;
  localparam logic [MBX_CODE_W-1:0] MBX_CHAR_HI   = 8'h7F;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic                  wr_en,
  input  logic [MBX_CODE_W-1:0] code,
  output mbx_kind_e             kind
);

  logic in_window;

  always_comb begin
    in_window = (code > MBX_CHAR_LO) && (code < MBX_CHAR_HI);
    kind      = MBX_IDLE;
    if (wr_en) begin
      if (code == MBX_CODE_PASS) begin
        kind = MBX_PASS;
      end else if (code == MBX_CODE_FAIL) begin
        kind = MBX_FAIL;
      end else if (in_window) begin
        kind = MBX_CHAR;
      end
    end
  end

endmodule

// File: rtl/mbx_cycle.sv
module mbx_cycle #(
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned TIMEOUT_CYCLES = 2_000_000,
  parameter int unsigned RELEASE_AFTER  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             limit_next,
  output logic             released
);

  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REL_AT   = CNT_W'(RELEASE_AFTER);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rel_q, rel_d;
  logic             cnt_en;

  // Next state: saturating count, sticky release once past the threshold
  always_comb begin
    cnt_en = (cnt_q != CNT_MAX);
    cnt_d  = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    rel_d = rel_q | (cnt_d > REL_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      rel_q <= rel_d;
    end
  end

  assign count      = cnt_q;
  assign limit_next = (cnt_q == LIMIT_M1);
  assign released   = rel_q;

endmodule

// File: rtl/mbx_result.sv
module mbx_result
  import mbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  mbx_kind_e             kind,
  input  logic [MBX_CODE_W-1:0] code,
  input  logic                  limit_next,
  output logic                  char_valid,
  output logic [MBX_CODE_W-1:0] char_byte,
  output logic                  pass_flag,
  output logic                  fail_flag,
  output logic                  done_flag,
  output logic                  timeout_flag
);

  logic                  cv_q, cv_d;
  logic [MBX_CODE_W-1:0] cb_q, cb_d;
  logic                  pass_q, pass_d;
  logic                  fail_q, fail_d;
  logic                  done_q, done_d;
  logic                  to_q, to_d;
  logic                  frozen;
  logic                  take_char, take_pass, take_fail, take_result;
  logic                  cb_en;

  always_comb begin
    frozen      = done_q | to_q;
    take_char   = !frozen && (kind == MBX_CHAR);
    take_pass   = !frozen && (kind == MBX_PASS);
    take_fail   = !frozen && (kind == MBX_FAIL);
    take_result = take_pass | take_fail;

    cv_d   = take_char;
    cb_en  = take_char;
    cb_d   = code;
    pass_d = pass_q | take_pass;
    fail_d = fail_q | take_fail;
    done_d = done_q | take_result;
    // A result on the budget edge wins over the timeout
    to_d   = to_q | (limit_next && !frozen && !take_result);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q   <= 1'b0;
      cb_q   <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      cv_q <= cv_d;
      if (cb_en) begin
        cb_q <= cb_d;
      end
      pass_q <= pass_d;
      fail_q <= fail_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign char_valid   = cv_q;
  assign char_byte    = cb_q;
  assign pass_flag    = pass_q;
  assign fail_flag    = fail_q;
  assign done_flag    = done_q;
  assign timeout_flag = to_q;

endmodule

// File: rtl/run_mailbox.sv
module run_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W         = 64,
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned TIMEOUT_CYCLES = 2_000_000,
  parameter int unsigned RELEASE_AFTER  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              char_valid,
  output logic [7:0]        char_byte,
  output logic              pass_flag,
  output logic              fail_flag,
  output logic              done_flag,
  output logic              timeout_flag,
  output logic              sys_rst_n,
  output logic [CNT_W-1:0]  cycle_count
);

  logic [MBX_CODE_W-1:0] code;
  mbx_kind_e             kind;
  logic                  limit_next;

  assign code = wr_data[MBX_CODE_W-1:0];

  generate
    if (DATA_W > MBX_CODE_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:MBX_CODE_W];
    end
  endgenerate

  mbx_decode u_decode (
    .wr_en (wr_en),
    .code  (code),
    .kind  (kind)
  );

  mbx_cycle #(
    .CNT_W          (CNT_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .RELEASE_AFTER  (RELEASE_AFTER)
  ) u_cycle (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (cycle_count),
    .limit_next (limit_next),
    .released   (sys_rst_n)
  );

  mbx_result u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .code         (code),
    .limit_next   (limit_next),
    .char_valid   (char_valid),
    .char_byte    (char_byte),
    .pass_flag    (pass_flag),
    .fail_flag    (fail_flag),
    .done_flag    (done_flag),
    .timeout_flag (timeout_flag)
  );

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W         = 64,
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned TIMEOUT_CYCLES = 2_000_000,
  parameter int unsigned RELEASE_AFTER  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              char_valid,
  input logic [7:0]        char_byte,
  input logic              pass_flag,
  input logic              fail_flag,
  input logic              done_flag,
  input logic              timeout_flag,
  input logic              sys_rst_n,
  input logic [CNT_W-1:0]  cycle_count
);

  localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] REL_AT = CNT_W'(RELEASE_AFTER);

  // R2
  char_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> ($past(wr_en) && ($past(wr_data[7:0]) > 8'h05) &&
                    ($past(wr_data[7:0]) < 8'h7F) && (char_byte == $past(wr_data[7:0]))));

  // R3
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_flag |=> pass_flag);

  // R4
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |=> fail_flag);

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> (pass_flag ^ fail_flag));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_count != '1) |=> (cycle_count == $past(cycle_count) + 1'b1));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n == (cycle_count > REL_AT));

  // R7
  timeout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (cycle_count == LIMIT));

  // R7
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag || timeout_flag) |=> (!char_valid && $stable(pass_flag) && $stable(fail_flag)));

  // R10
  exclusive_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_flag && timeout_flag));

endmodule

bind run_mailbox mbx_checker #(
  .DATA_W         (DATA_W),
  .CNT_W          (CNT_W),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
  .RELEASE_AFTER  (RELEASE_AFTER)
) u_mbx_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .char_valid   (char_valid),
  .char_byte    (char_byte),
  .pass_flag    (pass_flag),
  .fail_flag    (fail_flag),
  .done_flag    (done_flag),
  .timeout_flag (timeout_flag),
  .sys_rst_n    (sys_rst_n),
  .cycle_count  (cycle_count)
);

// File: tb/run_mailbox_tb.sv
module run_mailbox_tb;

  localparam int unsigned DW    = 32;
  localparam int unsigned CW    = 32;
  localparam int unsigned LIMIT = 300;
  localparam int unsigned REL   = 5;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          char_valid;
  logic [7:0]    char_byte;
  logic          pass_flag, fail_flag, done_flag, timeout_flag, sys_rst_n;
  logic [CW-1:0] cycle_count;

  int n_chk;
  int n_bad;

  run_mailbox #(
    .DATA_W (DW), .CNT_W (CW), .TIMEOUT_CYCLES (LIMIT), .RELEASE_AFTER (REL)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .char_valid (char_valid), .char_byte (char_byte),
    .pass_flag (pass_flag), .fail_flag (fail_flag), .done_flag (done_flag),
    .timeout_flag (timeout_flag), .sys_rst_n (sys_rst_n), .cycle_count (cycle_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one write at a negedge; returns at the negedge after the capture edge
  task automatic put(input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic do_reset();
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    tick(3);
    rst_n   = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(cycle_count == 0, "R11 count", 64'(cycle_count), 0);
    chk({char_valid, pass_flag, fail_flag, done_flag, timeout_flag, sys_rst_n} == 6'b0,
        "R11 flags", 64'({char_valid, pass_flag, fail_flag, done_flag, timeout_flag, sys_rst_n}), 0);
    chk(char_byte == 8'h00, "R11 char_byte", 64'(char_byte), 0);
  endtask

  task automatic t_counter_release();
    do_reset();
    for (int i = 0; i < 12; i++) begin
      chk(cycle_count == CW'(i), "R6 count step", 64'(cycle_count), 64'(i));
      chk(sys_rst_n == (i > REL), "R8 release", 64'(sys_rst_n), 64'(i > REL));
      tick(1);
    end
  endtask

  task automatic t_chars();
    logic [7:0] codes [4] = '{8'h06, 8'h41, 8'h7E, 8'h20};
    do_reset();
    foreach (codes[i]) begin
      put(DW'(codes[i]));
      chk(char_valid == 1'b1, "R2 valid", 64'(char_valid), 1);
      chk(char_byte == codes[i], "R2 byte", 64'(char_byte), 64'(codes[i]));
    end
    tick(1);
    chk(char_valid == 1'b0, "R2 one-cycle pulse", 64'(char_valid), 0);
    chk(char_byte == 8'h20, "R2 byte holds", 64'(char_byte), 64'h20);
  endtask

  task automatic t_upper_bits();
    do_reset();
    put(32'hABCD_EF41);
    chk(char_valid && char_byte == 8'h41, "R1 upper bits ignored char", 64'(char_byte), 64'h41);
    put(32'h1234_5600);
    chk(char_valid == 1'b0 && !done_flag, "R1 upper bits with 0x00", 64'(char_valid), 0);
    put(32'h0000_01FF);
    chk(pass_flag == 1'b1, "R1 upper bits with pass", 64'(pass_flag), 1);
  endtask

  task automatic t_ignored_codes();
    logic [7:0] codes [6] = '{8'h00, 8'h02, 8'h05, 8'h7F, 8'h80, 8'hFE};
    do_reset();
    put(DW'(8'h33));
    foreach (codes[i]) begin
      put(DW'(codes[i]));
      chk({char_valid, pass_flag, fail_flag, done_flag} == 4'b0, "R5 ignored code",
          64'({char_valid, pass_flag, fail_flag, done_flag}), 0);
    end
    chk(char_byte == 8'h33, "R5 byte untouched", 64'(char_byte), 64'h33);
  endtask

  task automatic t_pass();
    do_reset();
    put(DW'(8'hFF));
    chk(pass_flag && done_flag && !fail_flag, "R3 pass set", 64'({pass_flag, done_flag, fail_flag}), 64'b110);
    tick(4);
    chk(pass_flag && done_flag, "R3 pass sticky", 64'({pass_flag, done_flag}), 64'b11);
  endtask

  task automatic t_fail_freeze();
    do_reset();
    put(DW'(8'h01));
    chk(fail_flag && done_flag && !pass_flag, "R4 fail set", 64'({fail_flag, done_flag, pass_flag}), 64'b110);
    put(DW'(8'h41));
    chk(char_valid == 1'b0, "R9 char after done", 64'(char_valid), 0);
    put(DW'(8'hFF));
    chk(!pass_flag && fail_flag, "R9 pass after done", 64'(pass_flag), 0);
    tick(LIMIT);
    chk(timeout_flag == 1'b0, "R9 no timeout after done", 64'(timeout_flag), 0);
    chk(fail_flag && done_flag, "R4 fail sticky", 64'({fail_flag, done_flag}), 64'b11);
  endtask

  task automatic t_timeout();
    do_reset();
    tick(LIMIT - 1);
    chk(timeout_flag == 1'b0, "R7 before budget", 64'(timeout_flag), 0);
    tick(1);
    chk(cycle_count == CW'(LIMIT), "R7 count at budget", 64'(cycle_count), 64'(LIMIT));
    chk(timeout_flag == 1'b1, "R7 timeout raised", 64'(timeout_flag), 1);
    put(DW'(8'h41));
    chk(char_valid == 1'b0, "R9 char after timeout", 64'(char_valid), 0);
    put(DW'(8'hFF));
    chk(!pass_flag && !done_flag, "R9 pass after timeout", 64'({pass_flag, done_flag}), 0);
    chk(timeout_flag == 1'b1, "R7 timeout sticky", 64'(timeout_flag), 1);
  endtask

  task automatic t_priority();
    do_reset();
    tick(LIMIT - 1);
    put(DW'(8'hFF));
    chk(cycle_count == CW'(LIMIT), "R10 count", 64'(cycle_count), 64'(LIMIT));
    chk(pass_flag && done_flag, "R10 result kept", 64'({pass_flag, done_flag}), 64'b11);
    chk(timeout_flag == 1'b0, "R10 timeout suppressed", 64'(timeout_flag), 0);
    tick(5);
    chk(timeout_flag == 1'b0, "R10 timeout stays clear", 64'(timeout_flag), 0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    tick(8);
    put(DW'(8'h52));
    put(DW'(8'h01));
    rst_n = 1'b0;
    #1;
    chk({char_valid, pass_flag, fail_flag, done_flag, timeout_flag, sys_rst_n} == 6'b0,
        "R11 async clear", 64'({char_valid, fail_flag, done_flag, sys_rst_n}), 0);
    chk(cycle_count == 0 && char_byte == 0, "R11 count/byte clear", 64'(cycle_count), 0);
    tick(1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    t_reset_state();
    t_counter_release();
    t_chars();
    t_upper_bits();
    t_ignored_codes();
    t_pass();
    t_fail_freeze();
    t_timeout();
    t_priority();
    t_reset_clears();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule